// File: doc/BRIEF.md
# Correlating Global-History Branch Predictor

This block predicts whether a conditional branch will be taken. It keeps a table of small saturating counters and a shift register that holds the outcomes of the most recently resolved branches. A lookup forms a table row from the current outcome history and the low bits of the branch address. The most significant bit of the counter in that row is returned as the prediction in the same cycle. The history value used for the lookup is returned with it. The fetch pipeline carries that history along with the branch until the branch resolves.

When a branch resolves, its address, its actual outcome and the history it was predicted with are presented on the update port. The counter in the row built from that carried history and address moves one step toward the outcome. The outcome is then shifted into the live history register. Different branches whose low address bits match can land on the same counter. No tag is stored. With the history length set to zero, the row is picked by address alone, as in a plain per-address table.

Both ports take one request per cycle. The lookup answer is combinational and has no back-pressure: the consumer must take it in the cycle that `lk_valid` is high. The update port is valid/ready with `up_ready` tied high, so an update is accepted in every cycle where `up_valid` is high. There is never back-pressure on either port.

Top module: `corr_branch_predictor`

## Requirements
- R1: After reset, every counter is 0 and the history register is 0, where 0 encodes not taken. Every lookup then returns `lk_taken` = 0 and `lk_hist` = 0.
- R2: A lookup reads row {history, pc[IDX_W-HIST_LEN-1:0]}. The history occupies the upper HIST_LEN bits of the row number.
- R3: Each accepted update shifts `up_taken` into history bit 0 and moves every bit up one place; the oldest bit is dropped. `lk_hist` shows the live history.
- R4: An update with `up_taken` = 1 raises the selected counter by one, and the counter stays at 2^CTR_W-1 once there.
- R5: An update with `up_taken` = 0 lowers the selected counter by one, and the counter stays at 0 once there.
- R6: `lk_taken` is 1 exactly when `lk_valid` is 1 and the counter's top bit is set. With 2-bit counters, states 2 and 3 predict taken.
- R7: The update writes row {`up_hist`, up_pc low bits}, using the carried history and not the live one.
- R8: A lookup and an update of the same row in the same cycle give the counter value from before that update.
- R9: Two addresses that match in the low IDX_W-HIST_LEN bits and are looked up under the same history share one counter.
- R10: In a cycle without `up_valid`, no counter and no history bit changes.
- R11: With HIST_LEN = 0, the row is pc[IDX_W-1:0], the history has no effect, and the block works as a per-address counter table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_pc | input | ADDR_W | Address of the branch to predict |
| lk_taken | output | 1 | Prediction, 1 = taken, same cycle |
| lk_hist | output | max(HIST_LEN,1) | History used for this lookup; zero when HIST_LEN = 0 |
| up_valid | input | 1 | Resolved-branch update valid |
| up_ready | output | 1 | Always 1 |
| up_pc | input | ADDR_W | Address of the resolved branch |
| up_hist | input | max(HIST_LEN,1) | History the resolved branch was predicted with |
| up_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
A wrong history bit shifts the row for every later lookup. It shows as a wrong `lk_hist` on the next lookup after the faulty update, and as predictions read from the wrong counters. A counter that steps wrongly, or fails to saturate, shows only once the top bit of that row is expected to flip. This can take up to two or three further updates of the same row. The bench therefore trains individual rows until they saturate and then reverses them. It also mixes in a long stream of pseudo-random traffic. A reference model compares the prediction and history on every lookup, for both the correlating and the address-only configuration.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int unsigned CTR_MAX_W = 8;

  // Move a saturating counter one step toward the outcome.
  function automatic logic [CTR_MAX_W-1:0] sat_step(
    input logic [CTR_MAX_W-1:0] cur,
    input logic [CTR_MAX_W-1:0] top,
    input logic                 up
  );
    logic [CTR_MAX_W-1:0] res;
    res = cur;
    if (up && cur != top) res = cur + 1'b1;
    else if (!up && cur != '0) res = cur - 1'b1;
    return res;
  endfunction
endpackage

// File: rtl/bp_history.sv
module bp_history #(
  parameter int unsigned HIST_LEN = 2,
  localparam int unsigned HW = (HIST_LEN > 0) ? HIST_LEN : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          shift_bit,
  output logic [HW-1:0] hist_o
);
  generate
    if (HIST_LEN == 0) begin : g_none
      logic unused_hist_in;
      assign unused_hist_in = ^{clk, rst, shift_en, shift_bit};
      assign hist_o = '0;
    end else begin : g_shift
      logic [HW-1:0] hist_q;
      always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else if (shift_en) hist_q <= HW'({hist_q, shift_bit});
      end
      assign hist_o = hist_q;

      AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> hist_q[0] == $past(shift_bit)); // R3
      AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(hist_q)); // R10
    end
  endgenerate
endmodule

// File: rtl/bp_index.sv
module bp_index #(
  parameter int unsigned HIST_LEN = 2,
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned ADDR_W   = 16,
  localparam int unsigned HW    = (HIST_LEN > 0) ? HIST_LEN : 1,
  localparam int unsigned LOW_W = IDX_W - HIST_LEN
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [HW-1:0]     hist,
  output logic [IDX_W-1:0]  idx
);
  logic unused_pc_high;
  assign unused_pc_high = ^pc[ADDR_W-1:LOW_W];

  generate
    if (HIST_LEN == 0) begin : g_addr_only
      logic unused_hist;
      assign unused_hist = ^hist;
      assign idx = pc[IDX_W-1:0];
    end else begin : g_corr
      assign idx = {hist, pc[LOW_W-1:0]};
    end
  endgenerate
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import bp_pkg::*;
#(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned CTR_W = 2,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam logic [CTR_W-1:0] TOP = {CTR_W{1'b1}};

  logic [CTR_W-1:0] mem [DEPTH];
  logic [CTR_W-1:0] cur;
  logic [CTR_W-1:0] nxt;

  assign cur    = mem[wr_idx];
  assign nxt    = CTR_W'(sat_step(CTR_MAX_W'(cur), CTR_MAX_W'(TOP), wr_taken));
  assign rd_ctr = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= nxt;
    end
  end

  AST_CTR_INC: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && cur != TOP) |=> mem[$past(wr_idx)] == CTR_W'($past(cur) + 1'b1)); // R4
  AST_CTR_SAT_HI: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && cur == TOP) |=> mem[$past(wr_idx)] == TOP); // R4
  AST_CTR_DEC: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken && cur != '0) |=> mem[$past(wr_idx)] == CTR_W'($past(cur) - 1'b1)); // R5
  AST_CTR_SAT_LO: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken && cur == '0) |=> mem[$past(wr_idx)] == '0); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (rd_idx != $past(rd_idx) || rd_ctr == $past(rd_ctr))); // R10
endmodule

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor #(
  parameter int unsigned HIST_LEN = 2,
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned CTR_W    = 2,
  parameter int unsigned ADDR_W   = 16,
  localparam int unsigned HW = (HIST_LEN > 0) ? HIST_LEN : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_taken,
  output logic [HW-1:0]     lk_hist,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [ADDR_W-1:0] up_pc,
  input  logic [HW-1:0]     up_hist,
  input  logic              up_taken
);
  logic [HW-1:0]    live_hist;
  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] wr_idx;
  logic [CTR_W-1:0] rd_ctr;
  logic             up_fire;

  assign up_ready = 1'b1;
  assign up_fire  = up_valid && up_ready;

  bp_history #(.HIST_LEN(HIST_LEN)) u_hist (
    .clk(clk), .rst(rst), .shift_en(up_fire), .shift_bit(up_taken), .hist_o(live_hist)
  );

  bp_index #(.HIST_LEN(HIST_LEN), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_rd_index (
    .pc(lk_pc), .hist(live_hist), .idx(rd_idx)
  );

  bp_index #(.HIST_LEN(HIST_LEN), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_wr_index (
    .pc(up_pc), .hist(up_hist), .idx(wr_idx)
  );

  bp_ctr_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_table (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_ctr(rd_ctr),
    .wr_en(up_fire), .wr_idx(wr_idx), .wr_taken(up_taken)
  );

  assign lk_taken = lk_valid && rd_ctr[CTR_W-1];
  assign lk_hist  = live_hist;

  AST_IDLE_PRED: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> !lk_taken); // R6
  AST_HIST_STILL: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> $stable(lk_hist)); // R10
endmodule

// File: tb/test_corr_branch_predictor.sv
module test_corr_branch_predictor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [15:0] lk_pc = '0;
  logic        up_valid = 1'b0;
  logic [15:0] up_pc = '0;
  logic [1:0]  up_hist = '0;
  logic        up_taken = 1'b0;

  logic        lk_taken, up_ready, lk_taken_f, up_ready_f;
  logic [1:0]  lk_hist;
  logic [0:0]  lk_hist_f;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  corr_branch_predictor #(.HIST_LEN(2), .IDX_W(6), .CTR_W(2), .ADDR_W(16)) i_corr_branch_predictor (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_hist(lk_hist), .up_valid(up_valid), .up_ready(up_ready), .up_pc(up_pc),
    .up_hist(up_hist), .up_taken(up_taken)
  );

  corr_branch_predictor #(.HIST_LEN(0), .IDX_W(6), .CTR_W(2), .ADDR_W(16)) i_corr_branch_predictor_flat (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_taken(lk_taken_f),
    .lk_hist(lk_hist_f), .up_valid(up_valid), .up_ready(up_ready_f), .up_pc(up_pc),
    .up_hist(up_hist[0]), .up_taken(up_taken)
  );

  typedef struct {
    logic       t;
    logic [1:0] h;
    logic       tf;
    string      tag;
  } exp_t;

  exp_t       expq[$];
  logic [1:0] mctr [64];
  logic [1:0] fctr [64];
  logic [1:0] mhist;

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] sat(input logic [1:0] c, input logic t);
    if (t && c != 2'd3) return c + 2'd1;
    if (!t && c != 2'd0) return c - 2'd1;
    return c;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 64; i++) begin mctr[i] = 2'd0; fctr[i] = 2'd0; end
    mhist = 2'd0;
  endtask

  // Driver: sets inputs for one cycle and pushes expected lookup results.
  task automatic step(input logic lv, input logic [15:0] lpc, input logic uv,
                      input logic [15:0] upc, input logic [1:0] uh, input logic ut,
                      input string tag);
    exp_t e;
    @(negedge clk);
    lk_valid = lv; lk_pc = lpc; up_valid = uv; up_pc = upc; up_hist = uh; up_taken = ut;
    if (lv) begin
      e.t   = mctr[{mhist, lpc[3:0]}][1];
      e.h   = mhist;
      e.tf  = fctr[lpc[5:0]][1];
      e.tag = tag;
      expq.push_back(e);
    end
    if (uv) begin
      mctr[{uh, upc[3:0]}] = sat(mctr[{uh, upc[3:0]}], ut);
      fctr[upc[5:0]]       = sat(fctr[upc[5:0]], ut);
      mhist                = {mhist[0], ut};
    end
  endtask

  // Monitor: compares outputs mid low phase against the scoreboard.
  always @(negedge clk) begin
    exp_t e;
    #2;
    if (expq.size() > 0) begin
      e = expq.pop_front();
      check({1'b0, lk_taken}, {1'b0, e.t}, e.tag, "prediction");
      check(lk_hist, e.h, "R3", "history");
      check({1'b0, lk_taken_f}, {1'b0, e.tf}, "R11", "address-only prediction");
    end
  end

  initial begin
    #(8 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check({1'b0, up_ready}, 2'd1, "R1", "up_ready");

    // R1: reset state visible at several addresses
    step(1, 16'h0000, 0, 0, 0, 0, "R1");
    step(1, 16'h0005, 0, 0, 0, 0, "R1");
    step(1, 16'h00F3, 0, 0, 0, 0, "R1");

    // R8: lookup and update of the same row, looping taken
    for (int i = 0; i < 6; i++) step(1, 16'h0024, 1, 16'h0024, mhist, 1, "R8");
    // R4 / R6: saturate upward then observe
    for (int i = 0; i < 4; i++) step(1, 16'h0024, 1, 16'h0024, mhist, 1, "R4");
    step(1, 16'h0024, 0, 0, 0, 0, "R6");
    // R5: reverse and saturate at zero
    for (int i = 0; i < 7; i++) step(1, 16'h0024, 1, 16'h0024, mhist, 0, "R5");
    step(1, 16'h0024, 0, 0, 0, 0, "R5");

    // R7: train a row under carried history 10 while the live history differs
    for (int i = 0; i < 3; i++) step(1, 16'h0031, 1, 16'h0031, 2'b10, 1, "R7");
    step(0, 0, 1, 16'h0002, mhist, 1, "R7");
    step(0, 0, 1, 16'h0002, mhist, 0, "R7");
    step(1, 16'h0031, 0, 0, 0, 0, "R7");

    // R9: train one address, look up an alias with the same low bits
    for (int i = 0; i < 4; i++) step(0, 0, 1, 16'h0013, mhist, 1, "R9");
    step(1, 16'h0213, 0, 0, 0, 0, "R9");
    step(1, 16'hA013, 0, 0, 0, 0, "R9");

    // R10: idle update port, many lookups, nothing changes
    for (int i = 0; i < 8; i++) step(1, 16'(i * 7), 0, 16'h0013, 2'b11, 0, "R10");

    // R2: pseudo-random mixed traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr;
      step(1, {8'h0, a[7:0]}, a[8], {8'h0, a[15:8]}, a[9] ? mhist : a[11:10], a[12] | a[13], "R2");
    end

    step(0, 0, 0, 0, 0, 0, "R2");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule